// File: doc/BRIEF.md
# I2C Target Engine with General-Call Decoding

This block is a bus target on a two-wire serial bus. It samples the clock and data wires through synchronisers and finds START and STOP conditions and clock edges. It matches a 7-bit own address and moves data through two small FIFOs, one for receiving and one for transmitting. The block decides the acknowledge bit for every byte. That decision uses the FIFO levels and a few control inputs. The data wire is never driven high: the block only pulls it low, through `sda_oe_o`, in open-drain style.

The block also recognises the broadcast (general-call) address, 0x00 or 0x01 with the direction bit ignored. It decodes the command byte that follows into a sticky interrupt flag and a two-bit call code. A first byte of 0x01 marks a hardware call. For a hardware call, the second byte is compared with an alternate-ID input. The host side is plain ports: enables, a refuse-writes request, push and pop strobes with show-ahead read data, and status flags.

Top module: `i2c_gcs_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `gc_irq_o` is 0, `gc_id_o` is 0, and both FIFOs report empty.
- R2: A first byte whose upper seven bits equal `own_addr_i` and whose bit 0 is 0 (write) is acknowledged. A first byte carrying any other non-broadcast address is not acknowledged, and the block ignores the bus until the next START.
- R3: During a write, each data byte is acknowledged and appended to the receive FIFO. The bytes are read back in arrival order.
- R4: When the receive FIFO is full, an incoming data byte is not acknowledged and is discarded. Reception continues with the next byte.
- R5: While `nack_req_i` is 1, the own write address is still acknowledged. Every data byte is refused, and the receive FIFO stays unchanged.
- R6: `early_tx_o` gives a one-cycle pulse on the eighth rising clock edge of an own address with bit 0 = 1 (read). If the transmit FIFO is still empty at the following falling clock edge, the read address is not acknowledged.
- R7: In a read, bytes leave the transmit FIFO MSB first, and SDA drive changes only while SCL is low. When the master acknowledges, the next byte is sent. When the master does not acknowledge, SDA is released and the transfer ends.
- R8: With `gc_en_i` set, a first byte of 0x00 or 0x01 is acknowledged. With `gc_en_i` clear, it is not acknowledged.
- R9: First byte 0x00 followed by 0x06: the byte is acknowledged, `gc_irq_o` is set, `gc_id_o` becomes 1, and both FIFOs are emptied.
- R10: First byte 0x00 followed by 0x04: the byte is acknowledged, `gc_irq_o` is set, and `gc_id_o` becomes 2. Any other command after 0x00 is not acknowledged and leaves the status unchanged.
- R11: First byte 0x01: the second byte is acknowledged only when `hgc_en_i` is 1. It sets `gc_irq_o` with `gc_id_o` = 3 only when it also equals `alt_id_i`.
- R12: A one-cycle `gc_clr_i` clears `gc_irq_o` and `gc_id_o` on the next cycle, and takes priority over a set in the same cycle.
- R13: Clearing `slv_en_i` releases SDA on the next cycle and returns the engine to idle.
- R14: A START seen partway through a byte abandons that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sda_oe_o | output | 1 | 1 pulls the data wire low |
| slv_en_i | input | 1 | Engine enable |
| gc_en_i | input | 1 | Accept broadcast addresses |
| hgc_en_i | input | 1 | Accept hardware broadcast calls |
| nack_req_i | input | 1 | Refuse all written data bytes |
| own_addr_i | input | 7 | Own 7-bit address |
| alt_id_i | input | 8 | Alternate ID compared with a hardware call's second byte |
| rx_pop_i | input | 1 | Remove the head of the receive FIFO |
| rx_data_o | output | 8 | Head of the receive FIFO |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |
| tx_push_i | input | 1 | Append `tx_data_i` to the transmit FIFO |
| tx_data_i | input | 8 | Byte to transmit |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |
| early_tx_o | output | 1 | Pulse: read address matched, load data now |
| gc_irq_o | output | 1 | Sticky broadcast-call status |
| gc_id_o | output | 2 | Broadcast-call code: 0 none, 1 reset, 2 command 4, 3 hardware |
| gc_clr_i | input | 1 | Clear the broadcast-call status |

## Verification
The hardest situation to reach from the pins is pulling the enable while the block is actively driving an acknowledge low. To get there, the bench clocks in an address bit by bit, stops just after the eighth falling edge, confirms that the drive is asserted, and only then drops the enable. A START partway through a byte is reached the same way: the bench emits four bits by hand and then issues a repeated START. The receive-overflow refusal is reached by writing one more byte than the FIFO depth in a single transfer. The whole broadcast-call decode space is covered by the table-driven loop.

// File: rtl/i2c_gcs_pkg.sv
package i2c_gcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_DECIDE,
        ST_ACK,
        ST_SEND,
        ST_MACK
    } gcs_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_DATA,
        BK_GCCMD
    } gcs_kind_e;

    localparam logic [7:0] GC_CMD_RESET = 8'h06;
    localparam logic [7:0] GC_CMD_FOUR  = 8'h04;

    localparam logic [1:0] GCID_NONE  = 2'd0;
    localparam logic [1:0] GCID_RESET = 2'd1;
    localparam logic [1:0] GCID_FOUR  = 2'd2;
    localparam logic [1:0] GCID_HW    = 2'd3;

    typedef struct packed {
        gcs_state_e st;
        gcs_kind_e  kind;
        gcs_state_e nxt;
        logic [7:0] sh;
        logic [3:0] cnt;
        logic       ack;
        logic       oe;
        logic       seen_rise;
        logic       hw;
        logic       more;
        logic       irq;
        logic [1:0] gcid;
    } gcs_core_s;

    localparam gcs_core_s CORE_RST = '{
        st: ST_IDLE, kind: BK_ADDR, nxt: ST_IDLE, sh: 8'h00, cnt: 4'd0,
        ack: 1'b0, oe: 1'b0, seen_rise: 1'b0, hw: 1'b0, more: 1'b0,
        irq: 1'b0, gcid: 2'd0
    };

endpackage

// File: rtl/i2c_gcs_sync.sv
module i2c_gcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int PW = STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] scl;
        logic [PW-1:0] sda;
    } pipe_s;

    pipe_s pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.scl = {pipe_q.scl[PW-2:0], scl_i};
        pipe_d.sda = {pipe_q.sda[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    logic scl_prev, sda_prev;

    assign scl_o      = pipe_q.scl[STAGES-1];
    assign sda_o      = pipe_q.sda[STAGES-1];
    assign scl_prev   = pipe_q.scl[STAGES];
    assign sda_prev   = pipe_q.sda[STAGES];
    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/i2c_gcs_fifo.sv
module i2c_gcs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_s;

    ptr_s p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (p_q.cnt == CW'(DEPTH));
    assign empty_o = (p_q.cnt == '0);
    assign do_push = push_i & ~full_o;
    assign do_pop  = pop_i & ~empty_o;
    assign rdata_o = mem_q[p_q.rp];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] v);
        return (v == AW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (flush_i) begin
            p_d = '0;
        end else begin
            if (do_push) p_d.wp = wrap_inc(p_q.wp);
            if (do_pop)  p_d.rp = wrap_inc(p_q.rp);
            case ({do_push, do_pop})
                2'b10:   p_d.cnt = p_q.cnt + 1'b1;
                2'b01:   p_d.cnt = p_q.cnt - 1'b1;
                default: p_d.cnt = p_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem_q[p_q.wp] <= wdata_i;
    end

endmodule

// File: rtl/i2c_gcs_slave.sv
module i2c_gcs_slave
    import i2c_gcs_pkg::*;
#(
    parameter int RX_DEPTH    = 4,
    parameter int TX_DEPTH    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       slv_en_i,
    input  logic       gc_en_i,
    input  logic       hgc_en_i,
    input  logic       nack_req_i,
    input  logic [6:0] own_addr_i,
    input  logic [7:0] alt_id_i,
    input  logic       rx_pop_i,
    output logic [7:0] rx_data_o,
    output logic       rx_empty_o,
    output logic       rx_full_o,
    input  logic       tx_push_i,
    input  logic [7:0] tx_data_i,
    output logic       tx_empty_o,
    output logic       tx_full_o,
    output logic       early_tx_o,
    output logic       gc_irq_o,
    output logic [1:0] gc_id_o,
    input  logic       gc_clr_i
);
    localparam int BYTE_BITS = 8;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic rx_push, tx_pop, fifo_flush;
    logic [7:0] tx_head;
    logic early_d;

    i2c_gcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    gcs_core_s q, d;

    i2c_gcs_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (fifo_flush),
        .push_i  (rx_push),
        .wdata_i (q.sh),
        .pop_i   (rx_pop_i),
        .rdata_o (rx_data_o),
        .full_o  (rx_full_o),
        .empty_o (rx_empty_o)
    );

    i2c_gcs_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (fifo_flush),
        .push_i  (tx_push_i),
        .wdata_i (tx_data_i),
        .pop_i   (tx_pop),
        .rdata_o (tx_head),
        .full_o  (tx_full_o),
        .empty_o (tx_empty_o)
    );

    // Next-state computation for the whole engine.
    always_comb begin
        d          = q;
        rx_push    = 1'b0;
        tx_pop     = 1'b0;
        fifo_flush = 1'b0;
        early_d    = 1'b0;

        unique case (q.st)
            ST_IDLE: ;

            ST_RECV: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == 4'(BYTE_BITS - 1)) begin
                        d.st = ST_DECIDE;
                        // read address: tell the host to load data before the ack slot
                        if (q.kind == BK_ADDR && d.sh[7:1] == own_addr_i && d.sh[0])
                            early_d = 1'b1;
                    end
                end
            end

            ST_DECIDE: begin
                if (scl_fall) begin
                    d.cnt       = '0;
                    d.seen_rise = 1'b0;
                    d.ack       = 1'b0;
                    d.nxt       = ST_IDLE;
                    d.st        = ST_ACK;
                    unique case (q.kind)
                        BK_ADDR: begin
                            if (q.sh[7:1] == own_addr_i) begin
                                if (q.sh[0]) begin
                                    if (!tx_empty_o) begin
                                        d.ack  = 1'b1;
                                        tx_pop = 1'b1;
                                        d.sh   = tx_head;
                                        d.nxt  = ST_SEND;
                                    end else begin
                                        d.st = ST_IDLE;
                                    end
                                end else begin
                                    d.ack  = 1'b1;
                                    d.nxt  = ST_RECV;
                                    d.kind = BK_DATA;
                                end
                            end else if (gc_en_i && q.sh[7:1] == 7'd0) begin
                                d.ack  = 1'b1;
                                d.nxt  = ST_RECV;
                                d.kind = BK_GCCMD;
                                d.hw   = q.sh[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end
                        BK_DATA: begin
                            d.nxt = ST_RECV;
                            if (!nack_req_i && !rx_full_o) begin
                                d.ack   = 1'b1;
                                rx_push = 1'b1;
                            end
                        end
                        BK_GCCMD: begin
                            d.nxt = ST_IDLE;
                            if (q.hw) begin
                                if (hgc_en_i) begin
                                    d.ack = 1'b1;
                                    if (q.sh == alt_id_i) begin
                                        d.irq  = 1'b1;
                                        d.gcid = GCID_HW;
                                    end
                                end
                            end else if (q.sh == GC_CMD_RESET) begin
                                d.ack      = 1'b1;
                                d.irq      = 1'b1;
                                d.gcid     = GCID_RESET;
                                fifo_flush = 1'b1;
                            end else if (q.sh == GC_CMD_FOUR) begin
                                d.ack  = 1'b1;
                                d.irq  = 1'b1;
                                d.gcid = GCID_FOUR;
                            end
                        end
                        default: d.st = ST_IDLE;
                    endcase
                    d.oe = (d.st == ST_ACK) && d.ack;
                end
            end

            ST_ACK: begin
                if (scl_rise) d.seen_rise = 1'b1;
                if (scl_fall && q.seen_rise) begin
                    d.st  = q.nxt;
                    d.cnt = '0;
                    d.oe  = (q.nxt == ST_SEND) ? ~q.sh[7] : 1'b0;
                end
            end

            ST_SEND: begin
                if (scl_rise) d.cnt = q.cnt + 1'b1;
                if (scl_fall) begin
                    if (q.cnt == 4'(BYTE_BITS)) begin
                        d.oe        = 1'b0;
                        d.st        = ST_MACK;
                        d.seen_rise = 1'b0;
                        d.more      = ~tx_empty_o;
                        if (!tx_empty_o) begin
                            tx_pop = 1'b1;
                            d.sh   = tx_head;
                        end
                    end else begin
                        d.oe = ~q.sh[3'd7 - q.cnt[2:0]];
                    end
                end
            end

            ST_MACK: begin
                if (scl_rise) begin
                    d.seen_rise = 1'b1;
                    d.ack       = ~sda_s;
                end
                if (scl_fall && q.seen_rise) begin
                    if (q.ack && q.more) begin
                        d.st  = ST_SEND;
                        d.cnt = '0;
                        d.oe  = ~q.sh[7];
                    end else begin
                        d.st = ST_IDLE;
                        d.oe = 1'b0;
                    end
                end
            end

            default: d.st = ST_IDLE;
        endcase

        if (bus_start) begin
            d.st        = ST_RECV;
            d.kind      = BK_ADDR;
            d.cnt       = '0;
            d.oe        = 1'b0;
            d.seen_rise = 1'b0;
            early_d     = 1'b0;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end

        if (!slv_en_i) begin
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
            early_d = 1'b0;
            rx_push = 1'b0;
            tx_pop  = 1'b0;
        end

        if (gc_clr_i) begin
            d.irq  = 1'b0;
            d.gcid = GCID_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    logic early_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) early_q <= 1'b0;
        else        early_q <= early_d;
    end

    assign sda_oe_o   = q.oe;
    assign early_tx_o = early_q;
    assign gc_irq_o   = q.irq;
    assign gc_id_o    = q.gcid;

endmodule

// File: rtl/i2c_gcs_chk.sv
module i2c_gcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slv_en,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       early,
    input logic       rx_push,
    input logic       rx_full,
    input logic       gc_irq,
    input logic [1:0] gc_id,
    input logic       gc_clr
);
    a_r13_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_en |=> !sda_oe);

    a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_en && !$stable(sda_oe)) |-> !scl_s);

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_push);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        early |=> !early);

    a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        gc_clr |=> (!gc_irq && gc_id == 2'd0));

    a_r9_irq_has_id: assert property (@(posedge clk) disable iff (!rst_n)
        gc_irq |-> (gc_id != 2'd0));

    a_r1_id_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !gc_irq |-> (gc_id == 2'd0));

endmodule

bind i2c_gcs_slave i2c_gcs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .slv_en  (slv_en_i),
    .sda_oe  (sda_oe_o),
    .scl_s   (scl_s),
    .early   (early_tx_o),
    .rx_push (rx_push),
    .rx_full (rx_full_o),
    .gc_irq  (gc_irq_o),
    .gc_id   (gc_id_o),
    .gc_clr  (gc_clr_i)
);

// File: tb/tb_i2c_gcs_slave.sv
`timescale 1ns/1ps
module tb_i2c_gcs_slave;
    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h2A;
    localparam logic [7:0] ALT = 8'h35;
    // {b1, b2, gc_en, hgc_en, ack1, ack2, irq, id}
    localparam int NV = 9;
    localparam logic [22:0] VEC [NV] = '{
        {8'h54, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        {8'h56, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        {8'h00, 8'h04, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2},
        {8'h00, 8'h06, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1},
        {8'h00, 8'h07, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {8'h00, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {8'h01, 8'h35, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3},
        {8'h01, 8'h36, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        {8'h01, 8'h35, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, m_sda = 1'b1;
    logic sda_line, sda_oe;
    logic slv_en = 1'b1, gc_en = 1'b1, hgc_en = 1'b1, nack_req = 1'b0;
    logic rx_pop = 1'b0, tx_push = 1'b0, gc_clr = 1'b0;
    logic [7:0] tx_data = 8'h00, rx_data;
    logic rx_empty, rx_full, tx_empty, tx_full, early, gc_irq;
    logic [1:0] gc_id;
    int n_chk = 0, n_err = 0, early_cnt = 0;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    i2c_gcs_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .slv_en_i(slv_en), .gc_en_i(gc_en), .hgc_en_i(hgc_en), .nack_req_i(nack_req),
        .own_addr_i(OWN), .alt_id_i(ALT), .rx_pop_i(rx_pop), .rx_data_o(rx_data),
        .rx_empty_o(rx_empty), .rx_full_o(rx_full), .tx_push_i(tx_push),
        .tx_data_i(tx_data), .tx_empty_o(tx_empty), .tx_full_o(tx_full),
        .early_tx_o(early), .gc_irq_o(gc_irq), .gc_id_o(gc_id), .gc_clr_i(gc_clr)
    );

    always @(posedge clk) if (early) early_cnt <= early_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; w(Q); scl = 1'b1; w(Q); m_sda = 1'b1; w(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; w(Q); scl = 1'b1; w(Q);
        ack = ~sda_line;
        w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl = 1'b1; w(Q); b[i] = sda_line; w(Q); scl = 1'b0;
        end
        m_sda = ~mack; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q); m_sda = 1'b1;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        b = rx_data; rx_pop = 1'b1; w(1); rx_pop = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_data = b; tx_push = 1'b1; w(1); tx_push = 1'b0;
    endtask

    task automatic pulse_clr();
        gc_clr = 1'b1; w(1); gc_clr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] b;
        int e0;
        w(5); rst_n = 1'b1; w(4);
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 gc_irq", gc_irq, 0);
        chk("R1 gc_id", gc_id, 0);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_empty", tx_empty, 1);

        // Table walk: R2 R3 R8 R10 R11 R12
        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VEC[v];
            gc_en = e[6]; hgc_en = e[5];
            do_start();
            write_byte(e[22:15], a);
            chk($sformatf("R2/R8 first-byte ack vec%0d", v), a, e[4]);
            if (e[4]) begin
                write_byte(e[14:7], a);
                chk($sformatf("R3/R10/R11 second-byte ack vec%0d", v), a, e[3]);
            end
            do_stop();
            chk($sformatf("R10/R11 irq vec%0d", v), gc_irq, e[2]);
            chk($sformatf("R9/R10/R11 id vec%0d", v), gc_id, e[1:0]);
            if (e[22:15] == 8'h54) begin
                pop_rx(b);
                chk("R3 rx data", b, e[14:7]);
            end
            pulse_clr();
            w(1);
            chk("R12 irq cleared", gc_irq, 0);
            chk("R12 id cleared", gc_id, 0);
        end
        gc_en = 1'b1; hgc_en = 1'b1;

        // R4 overflow: depth 4, fifth byte refused
        do_start();
        write_byte(8'h54, a);
        for (int i = 0; i < 5; i++) begin
            write_byte(8'h10 + 8'(i), a);
            chk($sformatf("R4 data ack byte%0d", i), a, (i < 4) ? 1 : 0);
        end
        do_stop();
        for (int i = 0; i < 4; i++) begin
            pop_rx(b);
            chk("R3 order after overflow", b, 8'h10 + 8'(i));
        end
        chk("R4 fifth discarded", rx_empty, 1);

        // R5 refuse writes
        nack_req = 1'b1;
        do_start();
        write_byte(8'h54, a);
        chk("R5 address still acked", a, 1);
        write_byte(8'h66, a);
        chk("R5 data refused", a, 0);
        write_byte(8'h67, a);
        chk("R5 data refused again", a, 0);
        do_stop();
        chk("R5 rx unchanged", rx_empty, 1);
        nack_req = 1'b0;

        // R6 read with empty transmit FIFO
        e0 = early_cnt;
        do_start();
        write_byte(8'h55, a);
        do_stop();
        chk("R6 empty read nacked", a, 0);
        chk("R6 early pulse", early_cnt - e0, 1);

        // R7 read two bytes, master ack then nack
        push_tx(8'hC3); push_tx(8'h5A);
        e0 = early_cnt;
        do_start();
        write_byte(8'h55, a);
        chk("R7 read address acked", a, 1);
        chk("R6 early pulse on read", early_cnt - e0, 1);
        read_byte(1'b1, b);
        chk("R7 first byte", b, 8'hC3);
        read_byte(1'b0, b);
        chk("R7 second byte", b, 8'h5A);
        chk("R7 released after master nack", sda_oe, 0);
        do_stop();
        chk("R7 tx drained", tx_empty, 1);

        // R9 reset call flushes FIFOs
        do_start();
        write_byte(8'h54, a);
        write_byte(8'h77, a);
        do_stop();
        push_tx(8'h99);
        chk("R9 rx loaded before call", rx_empty, 0);
        do_start();
        write_byte(8'h00, a);
        write_byte(8'h06, a);
        do_stop();
        chk("R9 ack", a, 1);
        chk("R9 irq", gc_irq, 1);
        chk("R9 id", gc_id, 1);
        chk("R9 rx flushed", rx_empty, 1);
        chk("R9 tx flushed", tx_empty, 1);
        pulse_clr();

        // R13 disable while driving an ack
        do_start();
        for (int i = 7; i >= 0; i--) send_bit(OWN[6:0] >> (i - 1) == 0 ? 1'b0 : (8'h54 >> i) & 1'b1);
        m_sda = 1'b1; w(2);
        chk("R13 ack being driven", sda_oe, 1);
        slv_en = 1'b0; w(2);
        chk("R13 released when disabled", sda_oe, 0);
        scl = 1'b1; w(Q); scl = 1'b0; w(Q);
        do_stop();
        slv_en = 1'b1;

        // R14 START in mid-byte restarts address reception
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        do_start();
        write_byte(8'h54, a);
        chk("R14 address after restart acked", a, 1);
        write_byte(8'h3C, a);
        do_stop();
        pop_rx(b);
        chk("R14 data after restart", b, 8'h3C);

        summary();
        $finish;
    end
endmodule